// File: doc/BRIEF.md
# Pseudo-Random Bit Error Rate Meter

This block measures the bit error rate of a demodulated serial stream that carries an 11-stage pseudo-random test pattern, which repeats every 2047 bits. It regenerates the same pattern on its own and needs no alignment input. It takes the first eleven accepted bits as the starting state of its generator. From then on it predicts every following bit and counts the accepted bits that differ from the prediction.

Mismatches are gathered over a fixed window of compared bits, 800,000 by default. At the end of each window the total is copied into a published 32-bit count, and the working total starts again from zero. A host reads the result through a byte-wide read port. Reading a dummy address takes a snapshot of the published count into a shadow copy. The four byte addresses then return that frozen snapshot, so a multi-byte read stays consistent while new windows complete. No read clears anything.

The block watches for lost alignment. It splits the compared bits into consecutive runs of 64. If more than 20 mismatches appear in one run, it drops its lock flag, reseeds from the incoming stream and throws away the window in progress.

Top module: `prbs_ber_meter`

## Requirements
- R1: The pattern follows x^11 + x^9 + 1: each bit equals the bit eleven positions earlier XOR the bit nine positions earlier. An error-free stream with lock held produces a published count of 0.
- R2: After reset or after loss of lock, the first 11 accepted bits load the generator and are not compared. The lock flag reads 1 from the clock edge that accepts the 11th of them.
- R3: A bit is accepted only on a clock edge with `bit_vld` high. Bits presented with `bit_vld` low change no state and no output.
- R4: A window spans WINDOW_BITS compared bits (default 800,000). `err_count` changes only on the edge that accepts the last bit of a window. It then takes the number of mismatches in that window, including that last bit.
- R5: The count is 32-bit unsigned. Addresses 1, 2, 3 and 4 return the shadow copy's bytes 0 (least significant) through 3.
- R6: Reads change neither `err_count` nor the working total. Reading the same byte twice returns the same value.
- R7: A read at address 0 copies the published count into the shadow and returns 0x00. The shadow holds until the next address-0 read. `rd_data` takes the addressed value on the edge where `rd_en` is high and holds otherwise.
- R8: Compared bits are split into consecutive runs of 64, starting at lock. The bit that brings a run's mismatches above 20 clears lock and discards the working window, leaving `err_count` unchanged; exactly 20 keeps lock.
- R9: The working total saturates at its all-ones value (2^ACC_W - 1) instead of wrapping, and restarts from zero in the next window.
- R10: `locked` shows the lock state. Address 5 returns it in bit 0 with the other bits 0. Addresses 6 and 7 return 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_in | input | 1 | Received data bit |
| bit_vld | input | 1 | High when bit_in carries a bit to accept |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Read address |
| rd_data | output | 8 | Registered read data |
| locked | output | 1 | Pattern lock flag |
| err_count | output | 32 | Published mismatch count of the last full window |

## Verification
The bench targets the loss threshold from both sides. A run with exactly 20 mismatches must keep lock; a design that counts with the wrong comparison would drop it. A run with 21 must drop lock, and the interrupted window must never be published; a design that kept the partial total would report a non-zero count after relock. A saturating window with more mismatches than the working total can hold must read all-ones, where a wrapping total would show a small number. Byte reads taken after a newer window has been published must still return the frozen snapshot, and reseeding must work from an arbitrary jump in the stream's phase.

// File: rtl/ber_meter_pkg.sv
package ber_meter_pkg;
    // generator length and feedback taps (x^11 + x^9 + 1)
    localparam int GEN_LEN = 11;
    localparam int TAP_HI  = 11;
    localparam int TAP_LO  = 9;

    // read port address map
    localparam int ADDR_W      = 3;
    localparam int ADDR_FREEZE = 0;
    localparam int ADDR_BYTE0  = 1;
    localparam int ADDR_STATUS = 5;
endpackage

// File: rtl/ber_lock_track.sv
module ber_lock_track
    import ber_meter_pkg::*;
#(
    parameter int RUN_LEN   = 64,
    parameter int RUN_LIMIT = 20
) (
    input  logic clk,
    input  logic rst_n,
    input  logic bit_in,
    input  logic bit_vld,
    output logic locked,
    output logic cmp_vld,
    output logic cmp_err,
    output logic lose
);
    localparam int SEED_W = $clog2(GEN_LEN + 1);
    localparam int RUN_W  = $clog2(RUN_LEN);
    localparam int ERR_W  = $clog2(RUN_LIMIT + 2);

    typedef struct packed {
        logic               lock;
        logic [SEED_W-1:0]  seed;
        logic [GEN_LEN-1:0] sr;
        logic [RUN_W-1:0]   run;
        logic [ERR_W-1:0]   rerr;
    } trk_t;

    trk_t st_d, st_q;
    logic pred, mis;
    logic [ERR_W-1:0] err_sum;

    always_comb begin
        st_d    = st_q;
        cmp_vld = 1'b0;
        cmp_err = 1'b0;
        lose    = 1'b0;
        pred    = st_q.sr[TAP_HI-1] ^ st_q.sr[TAP_LO-1];
        mis     = bit_in ^ pred;
        err_sum = st_q.rerr + ERR_W'(mis);
        if (bit_vld) begin
            if (!st_q.lock) begin
                // seeding: load received bits, no comparison
                st_d.sr = {st_q.sr[GEN_LEN-2:0], bit_in};
                if (st_q.seed == SEED_W'(GEN_LEN - 1)) begin
                    st_d.lock = 1'b1;
                    st_d.seed = '0;
                    st_d.run  = '0;
                    st_d.rerr = '0;
                end else begin
                    st_d.seed = st_q.seed + 1'b1;
                end
            end else if (err_sum > ERR_W'(RUN_LIMIT)) begin
                lose      = 1'b1;
                st_d.lock = 1'b0;
                st_d.seed = '0;
            end else begin
                cmp_vld = 1'b1;
                cmp_err = mis;
                // free-running: feed back the prediction, not the received bit
                st_d.sr = {st_q.sr[GEN_LEN-2:0], pred};
                if (st_q.run == RUN_W'(RUN_LEN - 1)) begin
                    st_d.run  = '0;
                    st_d.rerr = '0;
                end else begin
                    st_d.run  = st_q.run + 1'b1;
                    st_d.rerr = err_sum;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked = st_q.lock;

    // R8: a loss event always clears lock on the next edge
    p_lose_unlocks_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lose |=> !locked);
    // R8: while locked, the run total never exceeds the limit
    p_run_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> (st_q.rerr <= ERR_W'(RUN_LIMIT)));
    // R2/R3: lock only rises on an accepted bit
    p_lock_needs_bit_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(bit_vld));
    // R3: nothing moves without a valid bit
    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !bit_vld |=> $stable(st_q));
endmodule

// File: rtl/ber_window.sv
module ber_window #(
    parameter int WINDOW_BITS = 800000,
    parameter int ACC_W       = 32,
    parameter int CNT_W       = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cmp_vld,
    input  logic             cmp_err,
    input  logic             lose,
    output logic [CNT_W-1:0] pub
);
    localparam int WIN_W = $clog2(WINDOW_BITS);
    localparam logic [ACC_W-1:0] ACC_MAX = '1;

    typedef struct packed {
        logic [WIN_W-1:0] wcnt;
        logic [ACC_W-1:0] acc;
        logic [ACC_W-1:0] pub;
    } win_t;

    win_t st_d, st_q;
    logic [ACC_W-1:0] acc_inc;
    logic win_end;

    always_comb begin
        st_d    = st_q;
        acc_inc = (st_q.acc == ACC_MAX) ? st_q.acc : st_q.acc + ACC_W'(cmp_err);
        win_end = cmp_vld && (st_q.wcnt == WIN_W'(WINDOW_BITS - 1));
        if (lose) begin
            st_d.wcnt = '0;
            st_d.acc  = '0;
        end else if (cmp_vld) begin
            if (win_end) begin
                st_d.pub  = acc_inc;
                st_d.wcnt = '0;
                st_d.acc  = '0;
            end else begin
                st_d.wcnt = st_q.wcnt + 1'b1;
                st_d.acc  = acc_inc;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    generate
        if (ACC_W < CNT_W) begin : g_pad
            assign pub = {{(CNT_W - ACC_W){1'b0}}, st_q.pub};
        end else begin : g_full
            assign pub = st_q.pub;
        end
    endgenerate

    // R4: the published value changes only after a compared bit
    p_pub_on_cmp_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.pub != $past(st_q.pub)) |-> $past(cmp_vld));
    // R8: a loss empties the working window
    p_discard_r8: assert property (@(posedge clk) disable iff (!rst_n)
        lose |=> (st_q.acc == '0 && st_q.wcnt == '0));
    // R9: a saturated total stays saturated within the window
    p_sat_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.acc == ACC_MAX && cmp_vld && !win_end && !lose) |=> (st_q.acc == ACC_MAX));
endmodule

// File: rtl/ber_read_port.sv
module ber_read_port
    import ber_meter_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [CNT_W-1:0]  pub,
    input  logic              locked,
    output logic [7:0]        rd_data
);
    localparam int NBYTES = CNT_W / 8;

    typedef struct packed {
        logic [CNT_W-1:0] shadow;
        logic [7:0]       rdata;
    } rp_t;

    rp_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_en) begin
            st_d.rdata = 8'h00;
            if (rd_addr == ADDR_W'(ADDR_FREEZE)) begin
                st_d.shadow = pub;
            end else if (rd_addr == ADDR_W'(ADDR_STATUS)) begin
                st_d.rdata = {7'b0, locked};
            end
            for (int i = 0; i < NBYTES; i++) begin
                if (rd_addr == ADDR_W'(ADDR_BYTE0 + i))
                    st_d.rdata = st_q.shadow[8*i +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rdata;

    // R7: the snapshot only moves on a freeze read
    p_shadow_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en && rd_addr == ADDR_W'(ADDR_FREEZE)) |=> $stable(st_q.shadow));
    // R7: read data holds between strobes
    p_rdata_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/prbs_ber_meter.sv
module prbs_ber_meter
    import ber_meter_pkg::*;
#(
    parameter int WINDOW_BITS = 800000,
    parameter int ACC_W       = 32,
    parameter int RUN_LEN     = 64,
    parameter int RUN_LIMIT   = 20
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bit_in,
    input  logic        bit_vld,
    input  logic        rd_en,
    input  logic [2:0]  rd_addr,
    output logic [7:0]  rd_data,
    output logic        locked,
    output logic [31:0] err_count
);
    localparam int CNT_W = 32;

    logic cmp_vld, cmp_err, lose;

    ber_lock_track #(.RUN_LEN(RUN_LEN), .RUN_LIMIT(RUN_LIMIT)) i_track (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .locked(locked), .cmp_vld(cmp_vld), .cmp_err(cmp_err), .lose(lose)
    );

    ber_window #(.WINDOW_BITS(WINDOW_BITS), .ACC_W(ACC_W), .CNT_W(CNT_W)) i_window (
        .clk(clk), .rst_n(rst_n), .cmp_vld(cmp_vld), .cmp_err(cmp_err),
        .lose(lose), .pub(err_count)
    );

    ber_read_port #(.CNT_W(CNT_W)) i_read (
        .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_addr(rd_addr),
        .pub(err_count), .locked(locked), .rd_data(rd_data)
    );

    // R6: no read strobe alters the published count
    p_read_keeps_count_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !bit_vld) |=> $stable(err_count));
endmodule

// File: tb/test_prbs_ber_meter.sv
module test_prbs_ber_meter;
    localparam int WIN    = 8192;
    localparam int ACCW   = 11;
    localparam int ACCMAX = (1 << ACCW) - 1;
    localparam int WDOG   = 190000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bit_in = 1'b0;
    logic        bit_vld = 1'b0;
    logic        rd_en = 1'b0;
    logic [2:0]  rd_addr = 3'd0;
    logic [7:0]  rd_data;
    logic        locked;
    logic [31:0] err_count;

    always #5 clk = ~clk;

    prbs_ber_meter #(.WINDOW_BITS(WIN), .ACC_W(ACCW)) i_prbs_ber_meter (
        .clk(clk), .rst_n(rst_n), .bit_in(bit_in), .bit_vld(bit_vld),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .locked(locked), .err_count(err_count)
    );

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;

    // stream generator state, newest bit at position 0
    logic [10:0] gen = 11'h5A3;

    // behavioural model of the requirements
    bit m_lock = 0;
    int m_seed = 0, m_run = 0, m_rerr = 0, m_wcnt = 0, m_acc = 0, m_nwin = 0;
    logic [31:0] m_pub = 0;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == WDOG) begin
            n_fail++;
            $display("FAIL R3 watchdog: actual=%0d expected<%0d cycles", cyc, WDOG);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    function automatic bit prbs_bit(input logic [10:0] h);
        // x^11 + x^9 + 1 (R1): bit n = bit n-11 ^ bit n-9
        return h[10] ^ h[8];
    endfunction

    task automatic model_step(input bit inj);
        int re;
        if (!m_lock) begin
            m_seed++;
            if (m_seed == 11) begin
                m_lock = 1; m_seed = 0; m_run = 0; m_rerr = 0;
            end
        end else begin
            re = m_rerr + int'(inj);
            if (re > 20) begin
                m_lock = 0; m_seed = 0; m_wcnt = 0; m_acc = 0;
            end else begin
                if (m_run == 63) begin m_run = 0; m_rerr = 0; end
                else begin m_run++; m_rerr = re; end
                if (!(m_acc == ACCMAX)) m_acc = m_acc + int'(inj);
                if (m_wcnt == WIN - 1) begin
                    m_pub = 32'(m_acc); m_acc = 0; m_wcnt = 0; m_nwin++;
                end else m_wcnt++;
            end
        end
    endtask

    task automatic send_bit(input bit v, input bit inj);
        bit sb;
        @(negedge clk);
        rd_en   = 1'b0;
        bit_vld = v;
        if (v) begin
            sb = prbs_bit(gen);
            gen = {gen[9:0], sb};
            bit_in = sb ^ inj;
        end else begin
            bit_in = 1'($urandom);  // R3: ignored when not valid
        end
        @(posedge clk);
        #1;
        if (v) model_step(inj);
        chk("R2/R10 lock flag", {31'b0, locked}, {31'b0, m_lock});
        chk("R3/R4 published count", err_count, m_pub);
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        @(negedge clk);
        bit_vld = 1'b0;
        rd_en   = 1'b1;
        rd_addr = a;
        @(posedge clk);
        #1;
        d = rd_data;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_bytes(input string req, input logic [31:0] val);
        logic [7:0] d;
        for (int i = 0; i < 4; i++) begin
            rd(3'(1 + i), d);
            chk(req, {24'b0, d}, {24'b0, val[8*i +: 8]});
        end
    endtask

    // mode 0: clean, 1: sparse random errors, 2: 17 errors at the head of every run
    task automatic run_window(input int mode);
        int target;
        bit v, inj;
        target = m_nwin + 1;
        while (m_nwin < target) begin
            v = ($urandom % 5) != 0;
            inj = 1'b0;
            if (v && m_lock) begin
                if (mode == 1) inj = ($urandom % 64) == 0;
                else if (mode == 2) inj = (m_run < 17);
            end
            send_bit(v, inj);
        end
    endtask

    task automatic burst(input int n);
        while (!(m_lock && m_run == 0)) send_bit(1'b1, 1'b0);
        for (int i = 0; i < n; i++) send_bit(1'b1, m_lock);
    endtask

    initial begin
        logic [7:0] d;
        logic [31:0] snap;
        void'($urandom(32'd4242));
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // reset state (R10, R4, R5)
        chk("R10 reset lock", {31'b0, locked}, 32'd0);
        chk("R4 reset count", err_count, 32'd0);
        rd(3'd5, d); chk("R10 status byte unlocked", {24'b0, d}, 32'd0);
        rd(3'd1, d); chk("R5 reset byte", {24'b0, d}, 32'd0);

        // R1: clean stream gives zero
        run_window(0);
        chk("R1 clean window", err_count, 32'd0);
        rd(3'd5, d); chk("R10 status byte locked", {24'b0, d}, 32'd1);
        rd(3'd6, d); chk("R10 unused address", {24'b0, d}, 32'd0);

        // R4/R5/R7: random errors, freeze and read
        run_window(1);
        snap = m_pub;
        chk("R4 window count", err_count, snap);
        rd(3'd0, d); chk("R7 freeze read data", {24'b0, d}, 32'd0);
        chk_bytes("R5 byte order", snap);

        // R7: new window does not disturb the snapshot; R6: no clearing
        run_window(1);
        chk_bytes("R7 snapshot held", snap);
        chk("R6 count after reads", err_count, m_pub);
        rd(3'd1, d); chk("R6 repeat read", {24'b0, d}, {24'b0, snap[7:0]});
        rd(3'd0, d);
        chk_bytes("R7 refreeze", m_pub);

        // R8: exactly 20 keeps lock, 21 loses it and discards the window
        burst(20);
        chk("R8 twenty errors keep lock", {31'b0, locked}, 32'd1);
        burst(21);
        chk("R8 21 errors drop lock", {31'b0, locked}, 32'd0);
        chk("R8 published kept at loss", err_count, m_pub);
        gen = 11'h2C7;  // R2: reseed from a new phase
        run_window(0);
        chk("R8 discarded window gives zero", err_count, 32'd0);

        // R9: saturation
        run_window(2);
        chk("R9 saturated count", err_count, 32'(ACCMAX));
        rd(3'd0, d);
        chk_bytes("R9 saturated bytes", 32'(ACCMAX));
        run_window(1);
        chk("R9 next window restarts", err_count, m_pub);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule